// File: doc/BRIEF.md
# Cold-Tier Batching Scheduler

This unit sits in front of a two-tier DRAM. Ranks of the hot tier are always active. Ranks of the cold tier are kept in self-refresh while they have nothing to do. Each incoming request carries a rank number and an address payload. A per-rank hot mask decides the tier.

Hot requests go straight to the hot output in the same cycle. Cold requests are held in a small queue while the cold ranks keep sleeping. A batch is released in one of two ways: the oldest held request has waited the configured maximum, or the queue has filled. When that happens the unit commands a self-refresh exit and waits the exit latency. It then drains the queue in arrival order, one request per cycle. Once the queue has stayed empty for a short idle window, it commands self-refresh entry again.

One exit and one entry therefore cover a whole group of cold accesses. The programmable wait bound keeps any single request from starving.

Top module: `cold_batch_sched`

## Requirements
- R1: After reset `pwr_state` is 0 (asleep), and `cold_valid`, `sr_exit` and `sr_enter` are low.
- R2: A request whose rank bit in `hot_mask` is 1 appears on `hot_valid`/`hot_rank`/`hot_addr` in the same cycle. It is not queued and does not wake the cold tier.
- R3: A cold request accepted by an empty queue while asleep causes `sr_exit` to pulse exactly `max_wait` cycles after the edge that accepted it.
- R4: When the queue holds 16 requests while asleep, `sr_exit` pulses in the next cycle, whatever the age.
- R5: While the queue is full, `req_ready` is low for cold requests, and a refused request is never output. Hot requests stay ready.
- R6: After `sr_exit`, `pwr_state` is 1 (exiting) for exactly `exit_lat` cycles and then becomes 2 (draining). `cold_valid` is high only in state 2.
- R7: In state 2 the queue drains one request per cycle in arrival order, with the rank and address unchanged.
- R8: A cold request accepted during draining joins the current batch and is output after the requests already held.
- R9: `sr_enter` pulses in the (`idle_win`+1)-th consecutive draining cycle in which the queue is empty and nothing arrives.
- R10: After `sr_enter`, `pwr_state` is 3 (entering) for exactly `entry_lat` cycles and then returns to 0.
- R11: A cold request accepted while entering is held. Its age counts from arrival, so once the unit is asleep again `sr_exit` follows at the point where `max_wait` is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_rank | input | RANK_W | Rank of the request |
| req_addr | input | ADDR_W | Address payload |
| hot_mask | input | 2**RANK_W | Bit r set marks rank r as hot |
| max_wait | input | AGE_W | Maximum hold time of a cold request, in cycles |
| exit_lat | input | TMR_W | Self-refresh exit latency, in cycles (at least 1) |
| entry_lat | input | TMR_W | Self-refresh entry time, in cycles (at least 1) |
| idle_win | input | TMR_W | Empty cycles required before re-entry |
| hot_valid | output | 1 | Hot request out |
| hot_rank | output | RANK_W | Hot request rank |
| hot_addr | output | ADDR_W | Hot request address |
| cold_valid | output | 1 | Cold request out (draining only) |
| cold_rank | output | RANK_W | Cold request rank |
| cold_addr | output | ADDR_W | Cold request address |
| sr_exit | output | 1 | Command: leave self-refresh |
| sr_enter | output | 1 | Command: enter self-refresh |
| pwr_state | output | 2 | 0 asleep, 1 exiting, 2 draining, 3 entering |

## Verification
The assertions take some things for granted about the inputs:
- `exit_lat` and `entry_lat` are at least 1.
- `max_wait` and the hot mask do not change while cold requests are held.
- The downstream sides accept every output in the cycle it is offered.

The stimulus respects this. It changes configuration only while the queue is empty or being drained, and it never depends on back-pressure from the outputs. It also drives requests only away from the clock edge.

// File: rtl/cold_batch_sched.sv
module cold_batch_sched #(
  parameter int RANK_W = 2,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  parameter int AGE_W  = 12,
  parameter int TMR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [RANK_W-1:0]     req_rank,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [(1<<RANK_W)-1:0] hot_mask,
  input  logic [AGE_W-1:0]      max_wait,
  input  logic [TMR_W-1:0]      exit_lat,
  input  logic [TMR_W-1:0]      entry_lat,
  input  logic [TMR_W-1:0]      idle_win,
  output logic                  hot_valid,
  output logic [RANK_W-1:0]     hot_rank,
  output logic [ADDR_W-1:0]     hot_addr,
  output logic                  cold_valid,
  output logic [RANK_W-1:0]     cold_rank,
  output logic [ADDR_W-1:0]     cold_addr,
  output logic                  sr_exit,
  output logic                  sr_enter,
  output logic [1:0]            pwr_state
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = RANK_W + ADDR_W;

  typedef enum logic [1:0] {SLEEP = 2'd0, EXITING = 2'd1, DRAINING = 2'd2, ENTERING = 2'd3} st_t;

  st_t              state, state_n;
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [AGE_W-1:0] age;
  logic [TMR_W-1:0] tmr, idle;
  logic             is_hot, full, push, pop, empty_quiet;

  assign is_hot      = hot_mask[req_rank];
  assign full        = count == CNT_W'(DEPTH);
  assign req_ready   = is_hot | ~full;
  assign push        = req_valid & ~is_hot & ~full;
  assign hot_valid   = req_valid & is_hot;
  assign hot_rank    = req_rank;
  assign hot_addr    = req_addr;
  assign cold_valid  = (state == DRAINING) && (count != '0);
  assign pop         = cold_valid;
  assign {cold_rank, cold_addr} = mem[rd_ptr];
  assign empty_quiet = (state == DRAINING) && (count == '0) && !push;
  assign sr_exit     = (state == SLEEP) && (count != '0) && (age >= max_wait || full);
  assign sr_enter    = empty_quiet && (idle == idle_win);
  assign pwr_state   = state;

  always_comb begin
    state_n = state;
    case (state)
      SLEEP:    if (sr_exit) state_n = EXITING;
      EXITING:  if (tmr == '0) state_n = DRAINING;
      DRAINING: if (sr_enter) state_n = ENTERING;
      ENTERING: if (tmr == '0) state_n = SLEEP;
      default:  state_n = SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {req_rank, req_addr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SLEEP;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      age    <= '0;
      tmr    <= '0;
      idle   <= '0;
    end else begin
      state <= state_n;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);

      if (state == DRAINING || count == '0) age <= '0;
      else if (age != {AGE_W{1'b1}})        age <= age + 1'b1;

      if (sr_exit)              tmr <= exit_lat - 1'b1;
      else if (sr_enter)        tmr <= entry_lat - 1'b1;
      else if (tmr != '0)       tmr <= tmr - 1'b1;

      if (empty_quiet && !sr_enter) idle <= idle + 1'b1;
      else                          idle <= '0;
    end
  end
endmodule

module cold_batch_sched_chk #(
  parameter int RANK_W = 2,
  parameter int AGE_W  = 12,
  parameter int TMR_W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [RANK_W-1:0]      req_rank,
  input logic [(1<<RANK_W)-1:0] hot_mask,
  input logic [AGE_W-1:0]       max_wait,
  input logic [TMR_W-1:0]       exit_lat,
  input logic [TMR_W-1:0]       entry_lat,
  input logic                   cold_valid,
  input logic                   sr_exit,
  input logic                   sr_enter,
  input logic [1:0]             pwr_state
);
  logic        pend;
  logic [31:0] sleep_wait, ex_cnt, en_cnt;
  logic        acc_cold;

  assign acc_cold = req_valid && req_ready && !hot_mask[req_rank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; sleep_wait <= '0; ex_cnt <= '0; en_cnt <= '0;
    end else begin
      pend <= (pwr_state == 2'd2) ? 1'b0 : (pend | acc_cold);
      if (!pend)                  sleep_wait <= '0;
      else if (pwr_state == 2'd0) sleep_wait <= sleep_wait + 1;
      ex_cnt <= (pwr_state == 2'd1) ? ex_cnt + 1 : '0;
      en_cnt <= (pwr_state == 2'd3) ? en_cnt + 1 : '0;
    end
  end

  a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pwr_state == 2'd0) |-> sleep_wait <= 32'(max_wait));
  a_r6_cold_only_draining: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd2) |-> !cold_valid);
  a_r6_exit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && $past(pwr_state) == 2'd0) |-> $past(sr_exit));
  a_r6_exit_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && $past(pwr_state) == 2'd1) |-> $past(ex_cnt) + 1 == 32'(exit_lat));
  a_r9_enter_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> !cold_valid && !sr_exit);
  a_r10_entry_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && $past(pwr_state) == 2'd3) |-> $past(en_cnt) + 1 == 32'(entry_lat));
endmodule

bind cold_batch_sched cold_batch_sched_chk #(.RANK_W(RANK_W), .AGE_W(AGE_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_rank(req_rank),
  .hot_mask(hot_mask), .max_wait(max_wait), .exit_lat(exit_lat), .entry_lat(entry_lat),
  .cold_valid(cold_valid), .sr_exit(sr_exit), .sr_enter(sr_enter), .pwr_state(pwr_state));

// File: tb/cold_batch_sched_test.sv
`timescale 1ns/1ps
module cold_batch_sched_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_rank = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  hot_mask = 4'b0011;
  logic [11:0] max_wait = 12'd6;
  logic [7:0]  exit_lat = 8'd3, entry_lat = 8'd2, idle_win = 8'd1;
  logic        hot_valid, cold_valid, sr_exit, sr_enter;
  logic [1:0]  hot_rank, cold_rank, pwr_state;
  logic [15:0] hot_addr, cold_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cold_batch_sched uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] r, input logic [15:0] a);
    req_valid = v; req_rank = r; req_addr = a;
  endtask

  task automatic wait_state(input logic [1:0] s);
    for (int g = 0; g < 2000 && pwr_state != s; g++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(pwr_state == 0 && !cold_valid && !sr_exit && !sr_enter, "R1", "reset outputs",
        {pwr_state, cold_valid, sr_exit, sr_enter}, 0);
  endtask

  task automatic t_hot();
    @(negedge clk); drive(1, 2'd1, 16'h1234); #1;
    chk(hot_valid && hot_rank == 1 && hot_addr == 16'h1234 && req_ready, "R2", "hot passthrough",
        {hot_valid, hot_addr}, {1'b1, 16'h1234});
    @(negedge clk); drive(0, 0, 0);
    repeat (12) @(negedge clk); #1;
    chk(pwr_state == 0 && !sr_exit, "R2", "hot left cold tier asleep", pwr_state, 0);
  endtask

  task automatic t_age();
    int n, e;
    @(negedge clk); drive(1, 2'd2, 16'h0055);
    @(negedge clk); drive(0, 0, 0); #1;
    n = 0;
    while (!sr_exit && n < 500) begin @(negedge clk); #1; n++; end
    chk(n == 6, "R3", "cycles to sr_exit", n, 6);
    @(negedge clk); #1;
    e = 0;
    while (pwr_state == 1 && e < 50) begin
      chk(!cold_valid, "R6", "no output while exiting", cold_valid, 0);
      @(negedge clk); #1; e++;
    end
    chk(e == 3, "R6", "exit length", e, 3);
    chk(pwr_state == 2 && cold_valid && cold_addr == 16'h0055 && cold_rank == 2, "R7", "single drained entry",
        cold_addr, 16'h0055);
    @(negedge clk); #1;
    chk(!sr_enter && !cold_valid, "R9", "no enter in first idle cycle", sr_enter, 0);
    @(negedge clk); #1;
    chk(sr_enter, "R9", "enter after idle window", sr_enter, 1);
    @(negedge clk); #1;
    e = 0;
    while (pwr_state == 3 && e < 50) begin @(negedge clk); #1; e++; end
    chk(e == 2 && pwr_state == 0, "R10", "entry length", e, 2);
  endtask

  task automatic t_full_join_enter();
    max_wait = 12'd1000;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); drive(1, 2'(2 + (i % 2)), 16'h0100 + 16'(i));
    end
    @(negedge clk); drive(1, 2'd3, 16'h01FF); #1;
    chk(sr_exit && pwr_state == 0, "R4", "full triggers exit", sr_exit, 1);
    chk(!req_ready, "R5", "cold refused while full", req_ready, 0);
    @(negedge clk); drive(1, 2'd0, 16'h0AAA); #1;
    chk(req_ready && hot_valid, "R5", "hot ready while full", req_ready, 1);
    @(negedge clk); drive(0, 0, 0);
    wait_state(2);
    max_wait = 12'd1;
    for (int i = 0; i < 18; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 3) drive(1, 2'd2, 16'h0777);
      if (i == 4) drive(0, 0, 0);
      #1;
      if (i < 16)
        chk(cold_valid && cold_addr == 16'h0100 + 16'(i) && cold_rank == 2'(2 + (i % 2)), "R7", "drain order",
            cold_addr, 16'h0100 + i);
      else if (i == 16)
        chk(cold_valid && cold_addr == 16'h0777, "R8", "late arrival joins batch", cold_addr, 16'h0777);
      else
        chk(!cold_valid, "R5", "refused request never output", cold_valid, 0);
    end
    @(negedge clk); #1;
    chk(sr_enter, "R9", "enter after batch", sr_enter, 1);
    @(negedge clk); drive(1, 2'd3, 16'h0333); #1;
    chk(pwr_state == 3, "R10", "entering state", pwr_state, 3);
    @(negedge clk); drive(0, 0, 0); #1;
    chk(pwr_state == 3 && !sr_exit, "R11", "held during entry", sr_exit, 0);
    @(negedge clk); #1;
    chk(pwr_state == 0 && sr_exit, "R11", "aged request wakes on sleep", sr_exit, 1);
    wait_state(2); #1;
    chk(cold_valid && cold_addr == 16'h0333, "R11", "held request drained", cold_addr, 16'h0333);
  endtask

  initial begin
    t_reset();
    t_hot();
    t_age();
    t_full_join_enter();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule